// File: doc/BRIEF.md
# Full-Search Block-Matching Motion Estimator

This block finds the best motion vector for one square reference block inside a square search window. It tries every displacement within ±P pixels in both directions. Each displacement has its own processing element (PE), which accumulates a sum of absolute differences (SAD) while the reference pixels stream past. When the block ends, a token walks down the PE chain once. At each PE the smaller of the running minimum and the local SAD is kept, together with that PE's location number. The last stage delivers the winning vector and its SAD.

The host works in two phases. It first writes the (N+2P)×(N+2P) search window in raster order through the window port. It then streams the N×N reference block in raster order, with a start-of-block strobe on the first pixel. The result appears as a single-cycle valid pulse with signed dx/dy and the minimum SAD. The centre PE (zero displacement) wins any tie with an equal SAD, so flat or static content resolves to the zero vector.

Top module: `me_full_search`

## Requirements
- R1: After reset, `mv_valid` stays low until a complete reference block has been streamed.
- R2: Each cycle with `win_we` high stores `win_pix` at the next raster position of the search window. `win_first` high places that pixel at position 0 and restarts the sequence from there.
- R3: A reference block is N×N pixels in raster order, with `ref_sob` high on pixel 0. The SAD of displacement (dx,dy) is the sum over (r,c) of |ref(r,c) − win(r+dy+P, c+dx+P)|, where the window has row width N+2P.
- R4: `mv_sad` equals the smallest SAD over all (2P+1)² displacements, and (`mv_dx`,`mv_dy`) is a displacement that attains it.
- R5: When several displacements share the minimum, the result is (0,0) if the zero displacement is among them. Otherwise the result is the first of them in scan order: dy ascending from −P, and within equal dy, dx ascending from −P.
- R6: `mv_dx` (horizontal) and `mv_dy` (vertical) are two's complement values in −P..P.
- R7: `mv_valid` is high for exactly one cycle. It goes high at the (2P+1)²+1-th rising edge, counting the edge that captures the last reference pixel as the first.
- R8: A block whose SAD is the full-scale value N²·(2^PW−1) on every displacement is reported exactly, as the zero vector.
- R9: A new block may start as soon as the previous result has been delivered. Its result depends only on its own pixels. `ref_sob` must not be raised while a comparison is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Search-window pixel write strobe |
| win_first | input | 1 | Marks the first window pixel (raster position 0) |
| win_pix | input | PW | Search-window pixel |
| ref_valid | input | 1 | Reference pixel valid |
| ref_sob | input | 1 | Start of reference block (pixel 0) |
| ref_pix | input | PW | Reference pixel |
| mv_valid | output | 1 | Result pulse |
| mv_dx | output | clog2(P+1)+1 | Signed horizontal displacement |
| mv_dy | output | clog2(P+1)+1 | Signed vertical displacement |
| mv_sad | output | PW+clog2(N²) | Minimum SAD |

## Verification
Random windows with the reference block cut out at a planted shift check the match at corner, edge and interior displacements. They show whether the SAD addressing and the location-to-vector decode agree. Flat content, at zero difference and at full-scale difference, makes every candidate tie. It separates the centre-preference rule from plain first-wins, and shows that a full-scale SAD still beats the seed. A pattern where only off-centre candidates tie at zero exercises first-in-scan-order selection. Restarted window loads and back-to-back blocks show that stale pointer or accumulator state does not leak into the next result.

// File: rtl/me_full_search.sv
module me_full_search #(
  parameter int PW = 8,
  parameter int N  = 4,
  parameter int P  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                win_we,
  input  logic                                win_first,
  input  logic [PW-1:0]                       win_pix,
  input  logic                                ref_valid,
  input  logic                                ref_sob,
  input  logic [PW-1:0]                       ref_pix,
  output logic                                mv_valid,
  output logic signed [$clog2(P+1):0]         mv_dx,
  output logic signed [$clog2(P+1):0]         mv_dy,
  output logic [PW+$clog2(N*N)-1:0]           mv_sad
);
  localparam int D   = 2*P+1;
  localparam int NC  = D*D;
  localparam int W   = N+2*P;
  localparam int WN  = W*W;
  localparam int AW  = PW+$clog2(N*N);
  localparam int LW  = $clog2(NC+1);
  localparam int VW  = $clog2(P+1)+1;
  localparam int CW  = $clog2(N);
  localparam int WAW = $clog2(WN);
  localparam int MID = D*P+P;

  logic [PW-1:0]  win [WN];
  logic [WAW-1:0] wptr, waddr;
  logic [CW-1:0]  row_q, col_q, cur_r, cur_c;
  logic           done, last_col, last_px;
  logic [NC-1:0]  tk;
  logic [AW-1:0]  acc [NC];
  logic [AW-1:0]  dm  [NC];
  logic [LW-1:0]  lc  [NC];
  int             li;

  assign waddr = win_first ? '0 : wptr;

  always_ff @(posedge clk)
    if (win_we && (32'(waddr) < WN)) win[waddr] <= win_pix;

  always_ff @(posedge clk)
    if (!rst_n)      wptr <= '0;
    else if (win_we) wptr <= waddr + 1'b1;

  assign cur_r    = ref_sob ? '0 : row_q;
  assign cur_c    = ref_sob ? '0 : col_q;
  assign last_col = (cur_c == CW'(N-1));
  assign last_px  = last_col && (cur_r == CW'(N-1));

  always_ff @(posedge clk)
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= ref_valid && last_px;
      if (ref_valid) begin
        col_q <= last_col ? '0 : cur_c + 1'b1;
        row_q <= last_col ? cur_r + 1'b1 : cur_r;
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) tk <= '0;
    else        tk <= {tk[NC-2:0], done};

  for (genvar i = 0; i < NC; i++) begin : g_pe
    localparam int OFF = (i / D) * W + (i % D);
    logic [WAW-1:0] yaddr;
    logic [PW-1:0]  ypix, ad;
    logic [AW-1:0]  din;
    logic [LW-1:0]  lin;
    logic           tin, take;

    assign yaddr = WAW'(int'(cur_r) * W + int'(cur_c) + OFF);
    assign ypix  = win[yaddr];
    assign ad    = (ref_pix > ypix) ? ref_pix - ypix : ypix - ref_pix;

    always_ff @(posedge clk)
      if (!rst_n)         acc[i] <= '0;
      else if (ref_valid) acc[i] <= (ref_sob ? '0 : acc[i]) + {{(AW-PW){1'b0}}, ad};

    if (i == 0) begin : g_head
      assign din = '1;
      assign lin = LW'(1);
      assign tin = done;
    end else begin : g_link
      assign din = dm[i-1];
      assign lin = lc[i-1];
      assign tin = tk[i-1];
    end

    if (i == MID) begin : g_mid
      assign take = (acc[i] <= din);
    end else begin : g_side
      assign take = (acc[i] < din);
    end

    always_ff @(posedge clk)
      if (!rst_n) begin
        dm[i] <= '1;
        lc[i] <= LW'(1);
      end else if (tin) begin
        dm[i] <= take ? acc[i] : din;
        lc[i] <= take ? LW'(i+1) : lin;
      end

    assert_chain_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tk[i] |-> (dm[i] <= $past(din)) && (dm[i] <= $past(acc[i])));
  end

  assign mv_valid = tk[NC-1];
  assign mv_sad   = dm[NC-1];

  always_comb begin
    li    = int'(lc[NC-1]) - 1;
    mv_dx = VW'(li % D - P);
    mv_dy = VW'(li / D - P);
  end

  assert_sob_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_sob |-> !(done || (|tk)));

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_dx >= -P) && (mv_dx <= P) && (mv_dy >= -P) && (mv_dy <= P));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |=> !mv_valid);

  assert_seed_beaten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mv_sad != '1);

  assert_token_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tk));
endmodule

// File: tb/me_full_search_test.sv
`timescale 1ns/1ps
module me_full_search_test;
  localparam int PW = 8, N = 4, P = 2;
  localparam int D = 2*P+1, NC = D*D, W = N+2*P, WN = W*W, NN = N*N;
  localparam int AW = PW+$clog2(NN), VW = $clog2(P+1)+1;

  logic clk = 0, rst_n = 0;
  logic win_we = 0, win_first = 0, ref_valid = 0, ref_sob = 0;
  logic [PW-1:0] win_pix = '0, ref_pix = '0;
  logic mv_valid;
  logic signed [VW-1:0] mv_dx, mv_dy;
  logic [AW-1:0] mv_sad;

  int total = 0, bad = 0;
  int win_m [WN];
  int ref_m [NN];
  int e_dx, e_dy, e_sad;

  me_full_search #(.PW(PW), .N(N), .P(P)) uut (
    .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_first(win_first), .win_pix(win_pix),
    .ref_valid(ref_valid), .ref_sob(ref_sob), .ref_pix(ref_pix),
    .mv_valid(mv_valid), .mv_dx(mv_dx), .mv_dy(mv_dy), .mv_sad(mv_sad));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model();
    int bs = 0, bl = 0;
    for (int l = 0; l < NC; l++) begin
      int s = 0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          int d = ref_m[r*N+c] - win_m[(r + l/D)*W + c + l%D];
          s += (d < 0) ? -d : d;
        end
      if (l == 0 || s < bs || (l == D*P+P && s <= bs)) begin
        bs = s;
        bl = l;
      end
    end
    e_sad = bs;
    e_dx = bl % D - P;
    e_dy = bl / D - P;
  endtask

  task automatic load_window(input int count, input int skip_first);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      win_we = 1;
      win_first = (k == 0 && skip_first == 0);
      win_pix = PW'(win_m[k]);
    end
    @(negedge clk);
    win_we = 0;
    win_first = 0;
  endtask

  task automatic run_block(input string req);
    int cnt = 1;
    model();
    for (int k = 0; k < NN; k++) begin
      @(negedge clk);
      ref_valid = 1;
      ref_sob = (k == 0);
      ref_pix = PW'(ref_m[k]);
    end
    @(negedge clk);
    ref_valid = 0;
    ref_sob = 0;
    while (!mv_valid && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == NC+1, "R7", "result latency", cnt, NC+1);
    chk(int'(mv_sad) == e_sad, req, "sad", int'(mv_sad), e_sad);
    chk(int'(mv_dx) == e_dx, req, "dx", int'(mv_dx), e_dx);
    chk(int'(mv_dy) == e_dy, req, "dy", int'(mv_dy), e_dy);
    @(negedge clk);
    chk(mv_valid == 0, "R7", "valid width", int'(mv_valid), 0);
  endtask

  task automatic rand_window();
    for (int k = 0; k < WN; k++) win_m[k] = int'($urandom_range(255));
  endtask

  task automatic plant(input int dx, input int dy);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        ref_m[r*N+c] = win_m[(r+dy+P)*W + c+dx+P];
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (mv_valid) seen++;
    end
    chk(seen == 0, "R1", "valid after reset", seen, 0);
  endtask

  task automatic t_planted();
    int sx [5] = '{-2, 2, 1, 0, -1};
    int sy [5] = '{-2, 2, -1, 1, 2};
    for (int t = 0; t < 5; t++) begin
      rand_window();
      load_window(WN, 0);
      plant(sx[t], sy[t]);
      run_block("R3");
      chk(int'(mv_dx) == sx[t] && int'(mv_dy) == sy[t], "R4", "planted shift dx*8+dy",
          int'(mv_dx)*8 + int'(mv_dy), sx[t]*8 + sy[t]);
    end
  endtask

  task automatic t_flat();
    for (int k = 0; k < WN; k++) win_m[k] = 77;
    load_window(WN, 0);
    for (int k = 0; k < NN; k++) ref_m[k] = 77;
    run_block("R5");
    for (int k = 0; k < NN; k++) ref_m[k] = 90;
    run_block("R5");
  endtask

  task automatic t_full_scale();
    for (int k = 0; k < WN; k++) win_m[k] = 255;
    load_window(WN, 0);
    for (int k = 0; k < NN; k++) ref_m[k] = 0;
    run_block("R8");
    chk(int'(mv_sad) == NN*255, "R8", "full-scale sad", int'(mv_sad), NN*255);
  endtask

  task automatic t_side_tie();
    for (int k = 0; k < WN; k++) win_m[k] = 0;
    win_m[5*W+5] = 200;
    load_window(WN, 0);
    for (int k = 0; k < NN; k++) ref_m[k] = 0;
    run_block("R5");
    chk(int'(mv_dx) == -P && int'(mv_dy) == -P, "R5", "first zero candidate dx",
        int'(mv_dx), -P);
  endtask

  task automatic t_random();
    for (int t = 0; t < 4; t++) begin
      rand_window();
      load_window(WN, 0);
      for (int k = 0; k < NN; k++) ref_m[k] = int'($urandom_range(255));
      run_block("R6");
    end
  endtask

  task automatic t_restart();
    int keep [WN];
    rand_window();
    keep = win_m;
    for (int k = 0; k < WN; k++) win_m[k] = 255 - keep[k];
    load_window(11, 0);
    win_m = keep;
    load_window(WN, 0);
    plant(1, 0);
    run_block("R2");
    chk(int'(mv_sad) == 0, "R2", "restart sad", int'(mv_sad), 0);
  endtask

  task automatic t_back_to_back();
    rand_window();
    load_window(WN, 0);
    plant(-1, 1);
    run_block("R9");
    plant(2, -2);
    run_block("R9");
    chk(int'(mv_dx) == 2 && int'(mv_dy) == -2, "R9", "second block dy", int'(mv_dy), -2);
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_planted();
    t_flat();
    t_full_scale();
    t_side_tie();
    t_random();
    t_restart();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule